// File: doc/BRIEF.md
# Directory Coherence Cache Node Controller

This block is the cache-side coherence agent of one processor node in a system where a home directory, not a shared bus, keeps memory blocks consistent. It holds a small direct-mapped write-back cache of one-word lines. Each line is Invalid, Shared (readable copy, memory current) or Exclusive (sole, writable, dirty copy). Processor accesses that hit finish locally. Misses become point-to-point request messages to the home node, and the processor waits until the matching data reply arrives.

The home node also talks to this block. It can drop a shared copy, pull the dirty data of an exclusive line back while keeping a readable copy, or pull the data back and drop the line. Such messages are served at once, even while a processor miss is waiting for its reply, so the node and its home node cannot wait on each other. The interconnect and the directory sit outside this block.

Addresses are word addresses. The low `IDX_W` bits select the line and the remaining bits form the tag. Outgoing message kinds are encoded 0 = read request, 1 = write/ownership request, 2 = dirty-data return. Incoming kinds are encoded 0 = drop copy, 1 = recall data keep copy, 2 = recall data and drop, 3 = data reply.

Top module: `dcn_node_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is 1, and `out_vld` and `cpu_rsp_vld` are 0. The first read of any address therefore produces a read request.
- R2: A read that hits a Shared or Exclusive line, or a write that hits an Exclusive line, raises `cpu_rsp_vld` in the cycle after acceptance and sends no message. A read hit returns the stored word, which includes data from earlier write hits.
- R3: A read to an Invalid or non-matching line sends kind 0 with the request address. When the kind 3 reply arrives, the reply data is returned to the processor and the line becomes Shared.
- R4: A write to a Shared line, or to an Invalid or non-matching line, sends kind 1 with the request address. When the reply arrives, the line becomes Exclusive and holds the write data.
- R5: A read miss whose line slot holds an Exclusive line with another tag first sends kind 2 with the victim address and victim data. It then sends kind 0, and the new line ends Shared.
- R6: A write miss whose slot holds an Exclusive line with another tag first sends kind 2 for the victim. It then sends kind 1, and the new line ends Exclusive.
- R7: Incoming kind 0 for a matching Shared line makes it Invalid. Kind 0 for an address whose tag does not match leaves the line unchanged.
- R8: Incoming kind 1 for a matching Exclusive line sends kind 2 with that address and its data, and leaves the line Shared with its data kept.
- R9: Incoming kind 2 for a matching Exclusive line sends kind 2 with that address and data, and makes the line Invalid.
- R10: Incoming home messages are served while a processor miss waits for its reply. Any data return they cause goes out before the reply is taken.
- R11: From the acceptance of a missing access until its reply is taken, `cpu_ready` is 0 and no processor response is given.
- R12: An incoming recall (kind 1) for a line that is not Exclusive sends no message and leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_vld | input | 1 | Processor access request, taken when `cpu_ready` is 1 |
| cpu_req_wr | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Block can take a processor access this cycle |
| cpu_rsp_vld | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Read data (for writes, the word now stored) |
| out_vld | output | 1 | Outgoing message valid |
| out_rdy | input | 1 | Interconnect takes the outgoing message |
| out_kind | output | 2 | 0 read request, 1 write request, 2 data return |
| out_addr | output | ADDR_W | Message address |
| out_data | output | DATA_W | Data of a data return |
| in_vld | input | 1 | Incoming message valid |
| in_rdy | output | 1 | Incoming message consumed this cycle |
| in_kind | input | 2 | 0 drop, 1 recall keep, 2 recall drop, 3 data reply |
| in_addr | input | ADDR_W | Incoming message address |
| in_data | input | DATA_W | Data of a reply |

## Verification
The bench aims at the conflict-slot cases. A miss that lands on a dirty line with a different tag must send the data return before the request. A design that skipped it would lose dirty data, and one that also evicted clean lines would send a stray message. Write hits on a Shared line must still go to the home node; a design that wrote silently would show no ownership request. A recall in the middle of an outstanding miss must be answered at once; a design that held it back until the reply would lose the ordering the directory depends on. A drop message with a foreign tag must leave the line alone, and a wrong state after a recall shows up on the next access as a missing or extra request.

// File: rtl/dcn_pkg.sv
package dcn_pkg;

   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_SHR = 2'd1,
      LN_EXC = 2'd2
   } line_st_t;

   typedef enum logic [1:0] {
      OUT_RDREQ = 2'd0,
      OUT_WRREQ = 2'd1,
      OUT_WBACK = 2'd2
   } out_kind_t;

   typedef enum logic [1:0] {
      IN_DROP     = 2'd0,
      IN_RECALL   = 2'd1,
      IN_RECDROP  = 2'd2,
      IN_REPLY    = 2'd3
   } in_kind_t;

endpackage

// File: rtl/dcn_line_store.sv
module dcn_line_store
   import dcn_pkg::*;
#(
   parameter int IDX_W      = 4,
   parameter int TAG_W      = 12,
   parameter int DATA_W     = 32,
   parameter bit CLEAR_DATA = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDX_W-1:0]   a_idx,
   output line_st_t           a_st,
   output logic [TAG_W-1:0]   a_tag,
   output logic [DATA_W-1:0]  a_data,
   input  logic [IDX_W-1:0]   b_idx,
   output line_st_t           b_st,
   output logic [TAG_W-1:0]   b_tag,
   output logic [DATA_W-1:0]  b_data,
   input  logic               c_we,
   input  logic [IDX_W-1:0]   c_idx,
   input  line_st_t           c_st,
   input  logic               f_we,
   input  logic [IDX_W-1:0]   f_idx,
   input  line_st_t           f_st,
   input  logic [TAG_W-1:0]   f_tag,
   input  logic [DATA_W-1:0]  f_data
);

   localparam int LINES = 1 << IDX_W;

   line_st_t           st_all   [LINES];
   logic [TAG_W-1:0]   tag_all  [LINES];
   logic [DATA_W-1:0]  data_all [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      line_st_t          st_r;
      logic [TAG_W-1:0]  tag_r;
      logic [DATA_W-1:0] data_r;
      logic              f_sel;
      logic              c_sel;

      assign f_sel = f_we && (f_idx == IDX_W'(i));
      assign c_sel = c_we && (c_idx == IDX_W'(i));

      // processor-side update wins over a home message on the same slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     st_r <= LN_INV;
         else if (f_sel) st_r <= f_st;
         else if (c_sel) st_r <= c_st;
      end

      always_ff @(posedge clk) begin
         if (f_sel) tag_r <= f_tag;
      end

      if (CLEAR_DATA) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     data_r <= '0;
            else if (f_sel) data_r <= f_data;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (f_sel) data_r <= f_data;
         end
      end

      assign st_all[i]   = st_r;
      assign tag_all[i]  = tag_r;
      assign data_all[i] = data_r;
   end

   assign a_st   = st_all[a_idx];
   assign a_tag  = tag_all[a_idx];
   assign a_data = data_all[a_idx];
   assign b_st   = st_all[b_idx];
   assign b_tag  = tag_all[b_idx];
   assign b_data = data_all[b_idx];

endmodule

// File: rtl/dcn_coh_resp.sv
module dcn_coh_resp
   import dcn_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int TAG_W  = 12,
   parameter int DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic [1:0]              in_kind,
   input  logic [IDX_W+TAG_W-1:0]  in_addr,
   input  logic [DATA_W-1:0]       in_data,
   input  logic                    out_rdy,
   output logic                    in_rdy,
   output logic [IDX_W-1:0]        look_idx,
   input  line_st_t                look_st,
   input  logic [TAG_W-1:0]        look_tag,
   input  logic [DATA_W-1:0]       look_data,
   output logic                    c_we,
   output logic [IDX_W-1:0]        c_idx,
   output line_st_t                c_st,
   output logic                    wb_vld,
   output logic [IDX_W+TAG_W-1:0]  wb_addr,
   output logic [DATA_W-1:0]       wb_data,
   output logic                    reply_vld,
   output logic [DATA_W-1:0]       reply_data
);

   localparam int ADDR_W = IDX_W + TAG_W;

   logic [TAG_W-1:0] msg_tag;
   logic             match;
   logic             upd;
   line_st_t         upd_st;

   assign look_idx = in_addr[IDX_W-1:0];
   assign msg_tag  = in_addr[ADDR_W-1:IDX_W];
   assign match    = (look_st != LN_INV) && (look_tag == msg_tag);

   always_comb begin
      upd    = 1'b0;
      upd_st = look_st;
      wb_vld = 1'b0;
      if (in_vld) begin
         unique case (in_kind_t'(in_kind))
            IN_DROP: begin
               if (match && look_st == LN_SHR) begin
                  upd    = 1'b1;
                  upd_st = LN_INV;
               end
            end
            IN_RECALL: begin
               if (match && look_st == LN_EXC) begin
                  wb_vld = 1'b1;
                  upd    = 1'b1;
                  upd_st = LN_SHR;
               end
            end
            IN_RECDROP: begin
               if (match && look_st == LN_EXC) begin
                  wb_vld = 1'b1;
                  upd    = 1'b1;
                  upd_st = LN_INV;
               end
            end
            default: ;
         endcase
      end
   end

   assign in_rdy     = wb_vld ? out_rdy : 1'b1;
   assign c_we       = upd && in_rdy;
   assign c_idx      = look_idx;
   assign c_st       = upd_st;
   assign wb_addr    = in_addr;
   assign wb_data    = look_data;
   assign reply_vld  = in_vld && (in_kind == 2'(IN_REPLY));
   assign reply_data = in_data;

   // R12: a recall that finds no dirty copy must never produce a data return
   a_r12_recall_needs_dirty : assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_kind == 2'(IN_RECALL) && look_st != LN_EXC) |-> !wb_vld);

   // R8/R9: a data return that is taken leaves the slot non-exclusive next cycle
   a_r8_recall_leaves_exc : assert property (@(posedge clk) disable iff (!rst_n)
      (wb_vld && out_rdy) |=> (look_idx != $past(look_idx)) || (look_st != LN_EXC));

endmodule

// File: rtl/dcn_miss_fsm.sv
module dcn_miss_fsm
   import dcn_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int TAG_W  = 12,
   parameter int DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_req_vld,
   input  logic                    cpu_req_wr,
   input  logic [IDX_W+TAG_W-1:0]  cpu_req_addr,
   input  logic [DATA_W-1:0]       cpu_req_wdata,
   output logic                    cpu_ready,
   output logic                    cpu_rsp_vld,
   output logic [DATA_W-1:0]       cpu_rsp_rdata,
   input  logic                    in_busy,
   output logic [IDX_W-1:0]        look_idx,
   input  line_st_t                look_st,
   input  logic [TAG_W-1:0]        look_tag,
   input  logic [DATA_W-1:0]       look_data,
   output logic                    f_we,
   output logic [IDX_W-1:0]        f_idx,
   output line_st_t                f_st,
   output logic [TAG_W-1:0]        f_tag,
   output logic [DATA_W-1:0]       f_data,
   input  logic                    reply_vld,
   input  logic [DATA_W-1:0]       reply_data,
   output logic                    req_vld,
   output logic [1:0]              req_kind,
   output logic [IDX_W+TAG_W-1:0]  req_addr,
   output logic [DATA_W-1:0]       req_data,
   input  logic                    req_gnt
);

   localparam int ADDR_W = IDX_W + TAG_W;

   typedef enum logic [1:0] {S_IDLE, S_EVICT, S_ASK, S_WAIT} fsm_t;

   fsm_t               st_q, st_d;
   logic               r_wr;
   logic [TAG_W-1:0]   r_tag;
   logic [IDX_W-1:0]   r_idx;
   logic [DATA_W-1:0]  r_wdata;

   logic [TAG_W-1:0]   in_tag;
   logic [IDX_W-1:0]   in_idx;
   logic               acc, line_hit, rd_hit, wr_hit, miss;
   logic               victim_dirty, evict_live;
   logic               rsp_d;
   logic [DATA_W-1:0]  rsp_data_d;

   assign in_tag       = cpu_req_addr[ADDR_W-1:IDX_W];
   assign in_idx       = cpu_req_addr[IDX_W-1:0];
   assign cpu_ready    = (st_q == S_IDLE) && !in_busy;
   assign acc          = cpu_req_vld && cpu_ready;
   assign look_idx     = (st_q == S_IDLE) ? in_idx : r_idx;
   assign line_hit     = (look_st != LN_INV) && (look_tag == in_tag);
   assign rd_hit       = acc && !cpu_req_wr && line_hit;
   assign wr_hit       = acc && cpu_req_wr && line_hit && (look_st == LN_EXC);
   assign miss         = acc && !rd_hit && !wr_hit;
   assign victim_dirty = (look_st == LN_EXC) && (look_tag != in_tag);
   assign evict_live   = (look_st == LN_EXC) && (look_tag != r_tag);

   always_comb begin
      st_d       = st_q;
      f_we       = 1'b0;
      f_idx      = r_idx;
      f_st       = LN_INV;
      f_tag      = r_tag;
      f_data     = r_wdata;
      req_vld    = 1'b0;
      req_kind   = 2'(OUT_RDREQ);
      req_addr   = {r_tag, r_idx};
      req_data   = '0;
      rsp_d      = 1'b0;
      rsp_data_d = look_data;
      unique case (st_q)
         S_IDLE: begin
            if (rd_hit) begin
               rsp_d = 1'b1;
            end else if (wr_hit) begin
               f_we       = 1'b1;
               f_idx      = in_idx;
               f_st       = LN_EXC;
               f_tag      = in_tag;
               f_data     = cpu_req_wdata;
               rsp_d      = 1'b1;
               rsp_data_d = cpu_req_wdata;
            end else if (miss) begin
               st_d = victim_dirty ? S_EVICT : S_ASK;
            end
         end
         S_EVICT: begin
            // a recall may already have taken the dirty copy away
            if (evict_live) begin
               req_vld  = 1'b1;
               req_kind = 2'(OUT_WBACK);
               req_addr = {look_tag, r_idx};
               req_data = look_data;
               if (req_gnt) begin
                  f_we   = 1'b1;
                  f_st   = LN_INV;
                  f_tag  = look_tag;
                  f_data = look_data;
                  st_d   = S_ASK;
               end
            end else begin
               st_d = S_ASK;
            end
         end
         S_ASK: begin
            req_vld  = 1'b1;
            req_kind = r_wr ? 2'(OUT_WRREQ) : 2'(OUT_RDREQ);
            req_data = r_wr ? r_wdata : '0;
            if (req_gnt) st_d = S_WAIT;
         end
         S_WAIT: begin
            if (reply_vld) begin
               f_we       = 1'b1;
               f_st       = r_wr ? LN_EXC : LN_SHR;
               f_data     = r_wr ? r_wdata : reply_data;
               rsp_d      = 1'b1;
               rsp_data_d = r_wr ? r_wdata : reply_data;
               st_d       = S_IDLE;
            end
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= S_IDLE;
         cpu_rsp_vld   <= 1'b0;
         cpu_rsp_rdata <= '0;
         r_wr          <= 1'b0;
         r_tag         <= '0;
         r_idx         <= '0;
         r_wdata       <= '0;
      end else begin
         st_q        <= st_d;
         cpu_rsp_vld <= rsp_d;
         if (rsp_d) cpu_rsp_rdata <= rsp_data_d;
         if (miss) begin
            r_wr    <= cpu_req_wr;
            r_tag   <= in_tag;
            r_idx   <= in_idx;
            r_wdata <= cpu_req_wdata;
         end
      end
   end

   // R2: an accepted hit answers in the following cycle
   a_r2_hit_answers : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit || wr_hit) |=> cpu_rsp_vld);

   // R11: while waiting without a reply, no answer and no new access
   a_r11_wait_blocks : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_WAIT && !reply_vld) |=> (!cpu_rsp_vld && !cpu_ready));

   // R5/R6: a granted victim return is always followed by the miss request
   a_r5_evict_then_ask : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_EVICT && req_vld && req_gnt) |=> (req_vld && req_kind != 2'(OUT_WBACK)));

endmodule

// File: rtl/dcn_node_ctrl.sv
module dcn_node_ctrl
   import dcn_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int IDX_W      = 4,
   parameter bit CLEAR_DATA = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req_vld,
   input  logic               cpu_req_wr,
   input  logic [ADDR_W-1:0]  cpu_req_addr,
   input  logic [DATA_W-1:0]  cpu_req_wdata,
   output logic               cpu_ready,
   output logic               cpu_rsp_vld,
   output logic [DATA_W-1:0]  cpu_rsp_rdata,
   output logic               out_vld,
   input  logic               out_rdy,
   output logic [1:0]         out_kind,
   output logic [ADDR_W-1:0]  out_addr,
   output logic [DATA_W-1:0]  out_data,
   input  logic               in_vld,
   output logic               in_rdy,
   input  logic [1:0]         in_kind,
   input  logic [ADDR_W-1:0]  in_addr,
   input  logic [DATA_W-1:0]  in_data
);

   localparam int TAG_W = ADDR_W - IDX_W;

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("dcn_node_ctrl: IDX_W must lie in 1..10");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("dcn_node_ctrl: ADDR_W must exceed IDX_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dcn_node_ctrl: DATA_W must be positive");
   end

   logic [IDX_W-1:0]  a_idx, b_idx, c_idx, f_idx;
   line_st_t          a_st, b_st, c_st, f_st;
   logic [TAG_W-1:0]  a_tag, b_tag, f_tag;
   logic [DATA_W-1:0] a_data, b_data, f_data;
   logic              c_we, f_we;

   logic              wb_vld;
   logic [ADDR_W-1:0] wb_addr;
   logic [DATA_W-1:0] wb_data;
   logic              reply_vld;
   logic [DATA_W-1:0] reply_data;

   logic              req_vld, req_gnt;
   logic [1:0]        req_kind;
   logic [ADDR_W-1:0] req_addr;
   logic [DATA_W-1:0] req_data;

   dcn_line_store #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .CLEAR_DATA(CLEAR_DATA)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
      .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
      .c_we(c_we), .c_idx(c_idx), .c_st(c_st),
      .f_we(f_we), .f_idx(f_idx), .f_st(f_st), .f_tag(f_tag), .f_data(f_data)
   );

   dcn_coh_resp #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
   ) u_resp (
      .clk(clk), .rst_n(rst_n),
      .in_vld(in_vld), .in_kind(in_kind), .in_addr(in_addr), .in_data(in_data),
      .out_rdy(out_rdy), .in_rdy(in_rdy),
      .look_idx(b_idx), .look_st(b_st), .look_tag(b_tag), .look_data(b_data),
      .c_we(c_we), .c_idx(c_idx), .c_st(c_st),
      .wb_vld(wb_vld), .wb_addr(wb_addr), .wb_data(wb_data),
      .reply_vld(reply_vld), .reply_data(reply_data)
   );

   dcn_miss_fsm #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_vld(cpu_req_vld), .cpu_req_wr(cpu_req_wr),
      .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
      .cpu_ready(cpu_ready), .cpu_rsp_vld(cpu_rsp_vld), .cpu_rsp_rdata(cpu_rsp_rdata),
      .in_busy(in_vld),
      .look_idx(a_idx), .look_st(a_st), .look_tag(a_tag), .look_data(a_data),
      .f_we(f_we), .f_idx(f_idx), .f_st(f_st), .f_tag(f_tag), .f_data(f_data),
      .reply_vld(reply_vld), .reply_data(reply_data),
      .req_vld(req_vld), .req_kind(req_kind), .req_addr(req_addr),
      .req_data(req_data), .req_gnt(req_gnt)
   );

   // home-node traffic owns the outgoing port whenever it needs it
   assign req_gnt  = !wb_vld && out_rdy;
   assign out_vld  = wb_vld || req_vld;
   assign out_kind = wb_vld ? 2'(OUT_WBACK) : req_kind;
   assign out_addr = wb_vld ? wb_addr : req_addr;
   assign out_data = wb_vld ? wb_data : req_data;

   // R10: a recall needing a data return is answered in the same cycle
   a_r10_recall_first : assert property (@(posedge clk) disable iff (!rst_n)
      wb_vld |-> (out_vld && out_kind == 2'(OUT_WBACK) && out_addr == in_addr));

   // R1: nothing leaves the node in the first cycle after reset
   a_r1_quiet_start : assert property (@(posedge clk)
      !rst_n |=> (!out_vld || !$past(!rst_n)) && !cpu_rsp_vld);

endmodule

// File: tb/dcn_node_ctrl_test.sv
`timescale 1ns/1ps
module dcn_node_ctrl_test;

   localparam int AW = 16;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req_vld = 1'b0;
   logic          cpu_req_wr = 1'b0;
   logic [AW-1:0] cpu_req_addr = '0;
   logic [DW-1:0] cpu_req_wdata = '0;
   logic          cpu_ready;
   logic          cpu_rsp_vld;
   logic [DW-1:0] cpu_rsp_rdata;
   logic          out_vld;
   logic          out_rdy = 1'b1;
   logic [1:0]    out_kind;
   logic [AW-1:0] out_addr;
   logic [DW-1:0] out_data;
   logic          in_vld = 1'b0;
   logic          in_rdy;
   logic [1:0]    in_kind = '0;
   logic [AW-1:0] in_addr = '0;
   logic [DW-1:0] in_data = '0;

   always #10 clk = ~clk;

   dcn_node_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_vld(cpu_req_vld), .cpu_req_wr(cpu_req_wr),
      .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
      .cpu_ready(cpu_ready), .cpu_rsp_vld(cpu_rsp_vld), .cpu_rsp_rdata(cpu_rsp_rdata),
      .out_vld(out_vld), .out_rdy(out_rdy), .out_kind(out_kind),
      .out_addr(out_addr), .out_data(out_data),
      .in_vld(in_vld), .in_rdy(in_rdy), .in_kind(in_kind),
      .in_addr(in_addr), .in_data(in_data)
   );

   localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2;
   localparam logic [1:0] I_DROP = 2'd0, I_REC = 2'd1, I_RECDROP = 2'd2, I_REPLY = 2'd3;

   typedef struct {
      logic [1:0]    kind;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      bit            chk_data;
      string         rq;
   } exp_t;

   exp_t  scb[$];
   int    errors = 0;
   int    checks = 0;
   string cur_rq = "R1";
   bit    done = 1'b0;

   task automatic check(bit ok, string rq, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic expect_msg(logic [1:0] k, logic [AW-1:0] a, logic [DW-1:0] d, bit cd, string rq);
      exp_t e;
      e.kind = k; e.addr = a; e.data = d; e.chk_data = cd; e.rq = rq;
      scb.push_back(e);
   endtask

   // monitor: every outgoing message is compared with the scoreboard head
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (rst_n && out_vld && out_rdy) begin
            if (scb.size() == 0) begin
               check(1'b0, cur_rq, "unexpected message addr", DW'(out_addr), '0);
            end else begin
               exp_t e;
               e = scb.pop_front();
               check(out_kind == e.kind, e.rq, "message kind", DW'(out_kind), DW'(e.kind));
               check(out_addr == e.addr, e.rq, "message addr", DW'(out_addr), DW'(e.addr));
               if (e.chk_data)
                  check(out_data == e.data, e.rq, "message data", out_data, e.data);
            end
         end
      end
   end

   task automatic cpu_issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      while (!cpu_ready) @(negedge clk);
      cpu_req_vld   = 1'b1;
      cpu_req_wr    = wr;
      cpu_req_addr  = a;
      cpu_req_wdata = d;
      @(negedge clk);
      cpu_req_vld   = 1'b0;
   endtask

   task automatic send_in(logic [1:0] k, logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      in_vld  = 1'b1;
      in_kind = k;
      in_addr = a;
      in_data = d;
      @(negedge clk);
      in_vld  = 1'b0;
   endtask

   task automatic hit_rd(logic [AW-1:0] a, logic [DW-1:0] exp, string rq);
      cur_rq = rq;
      cpu_issue(1'b0, a, '0);
      #5;
      check(cpu_rsp_vld == 1'b1, rq, "read hit response cycle", DW'(cpu_rsp_vld), 1);
      check(cpu_rsp_rdata == exp, rq, "read hit data", cpu_rsp_rdata, exp);
   endtask

   task automatic hit_wr(logic [AW-1:0] a, logic [DW-1:0] d, string rq);
      cur_rq = rq;
      cpu_issue(1'b1, a, d);
      #5;
      check(cpu_rsp_vld == 1'b1, rq, "write hit response cycle", DW'(cpu_rsp_vld), 1);
   endtask

   task automatic do_miss(bit wr, logic [AW-1:0] a, logic [DW-1:0] wd, logic [DW-1:0] reply,
                          bit chk, logic [DW-1:0] exp, string rq);
      cur_rq = rq;
      cpu_issue(wr, a, wd);
      repeat (3) @(negedge clk);
      #5;
      check(cpu_ready == 1'b0, "R11", "ready while miss pending", DW'(cpu_ready), 0);
      check(cpu_rsp_vld == 1'b0, "R11", "early response", DW'(cpu_rsp_vld), 0);
      check(scb.size() == 0, rq, "messages still missing", DW'(scb.size()), 0);
      send_in(I_REPLY, a, reply);
      #5;
      check(cpu_rsp_vld == 1'b1, rq, "miss response after reply", DW'(cpu_rsp_vld), 1);
      if (chk) check(cpu_rsp_rdata == exp, rq, "miss data", cpu_rsp_rdata, exp);
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #5;
      check(cpu_rsp_vld == 1'b0, "R1", "rsp during reset", DW'(cpu_rsp_vld), 0);
      check(out_vld == 1'b0, "R1", "out during reset", DW'(out_vld), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #5;
      check(cpu_ready == 1'b1, "R1", "ready after reset", DW'(cpu_ready), 1);
      check(out_vld == 1'b0, "R1", "out after reset", DW'(out_vld), 0);

      // R1 R3: cold read misses, reply fills Shared
      expect_msg(K_RD, 16'h0013, '0, 1'b0, "R3");
      do_miss(1'b0, 16'h0013, '0, 32'hAAAA0001, 1'b1, 32'hAAAA0001, "R3");
      hit_rd(16'h0013, 32'hAAAA0001, "R2");

      // R4: write to Shared asks for ownership
      expect_msg(K_WR, 16'h0013, '0, 1'b0, "R4");
      do_miss(1'b1, 16'h0013, 32'h0000_0011, 32'hDEAD0000, 1'b0, '0, "R4");
      hit_wr(16'h0013, 32'h0000_0022, "R2");
      hit_rd(16'h0013, 32'h0000_0022, "R2");

      // R5: read miss over a dirty victim
      expect_msg(K_WB, 16'h0013, 32'h0000_0022, 1'b1, "R5");
      expect_msg(K_RD, 16'h0023, '0, 1'b0, "R5");
      do_miss(1'b0, 16'h0023, '0, 32'hBBBB0002, 1'b1, 32'hBBBB0002, "R5");
      hit_rd(16'h0023, 32'hBBBB0002, "R5");
      expect_msg(K_WR, 16'h0023, '0, 1'b0, "R5");
      do_miss(1'b1, 16'h0023, 32'h0000_0033, 32'h0, 1'b0, '0, "R5");

      // R6: write miss over a dirty victim
      expect_msg(K_WB, 16'h0023, 32'h0000_0033, 1'b1, "R6");
      expect_msg(K_WR, 16'h0033, '0, 1'b0, "R6");
      do_miss(1'b1, 16'h0033, 32'h0000_0040, 32'h0, 1'b0, '0, "R6");
      hit_wr(16'h0033, 32'h0000_0044, "R6");
      hit_rd(16'h0033, 32'h0000_0044, "R6");

      // R8: recall keeps a readable copy
      cur_rq = "R8";
      expect_msg(K_WB, 16'h0033, 32'h0000_0044, 1'b1, "R8");
      send_in(I_REC, 16'h0033, '0);
      hit_rd(16'h0033, 32'h0000_0044, "R8");
      expect_msg(K_WR, 16'h0033, '0, 1'b0, "R8");
      do_miss(1'b1, 16'h0033, 32'h0000_0055, 32'h0, 1'b0, '0, "R8");

      // R9: recall-and-drop
      cur_rq = "R9";
      expect_msg(K_WB, 16'h0033, 32'h0000_0055, 1'b1, "R9");
      send_in(I_RECDROP, 16'h0033, '0);
      expect_msg(K_RD, 16'h0033, '0, 1'b0, "R9");
      do_miss(1'b0, 16'h0033, '0, 32'h0000_0066, 1'b1, 32'h0000_0066, "R9");

      // R7: drop with foreign tag is ignored, matching drop invalidates
      cur_rq = "R7";
      send_in(I_DROP, 16'h0043, '0);
      hit_rd(16'h0033, 32'h0000_0066, "R7");
      cur_rq = "R7";
      send_in(I_DROP, 16'h0033, '0);
      expect_msg(K_RD, 16'h0033, '0, 1'b0, "R7");
      do_miss(1'b0, 16'h0033, '0, 32'h0000_0077, 1'b1, 32'h0000_0077, "R7");

      // R12: recall of a Shared line does nothing
      cur_rq = "R12";
      send_in(I_REC, 16'h0033, '0);
      hit_rd(16'h0033, 32'h0000_0077, "R12");

      // R10: recall served while a miss waits
      expect_msg(K_WR, 16'h0105, '0, 1'b0, "R10");
      do_miss(1'b1, 16'h0105, 32'h0000_0088, 32'h0, 1'b0, '0, "R10");
      cur_rq = "R10";
      expect_msg(K_RD, 16'h0007, '0, 1'b0, "R10");
      cpu_issue(1'b0, 16'h0007, '0);
      repeat (2) @(negedge clk);
      expect_msg(K_WB, 16'h0105, 32'h0000_0088, 1'b1, "R10");
      send_in(I_REC, 16'h0105, '0);
      #5;
      check(scb.size() == 0, "R10", "recall return missing during wait", DW'(scb.size()), 0);
      check(cpu_ready == 1'b0, "R11", "ready before reply", DW'(cpu_ready), 0);
      send_in(I_REPLY, 16'h0007, 32'h0000_0099);
      #5;
      check(cpu_rsp_vld == 1'b1, "R10", "response after reply", DW'(cpu_rsp_vld), 1);
      check(cpu_rsp_rdata == 32'h0000_0099, "R10", "reply data", cpu_rsp_rdata, 32'h0000_0099);
      hit_rd(16'h0105, 32'h0000_0088, "R10");

      repeat (3) @(negedge clk);
      #5;
      check(scb.size() == 0, cur_rq, "unsent expected messages", DW'(scb.size()), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule